// File: doc/BRIEF.md
# MDIO Management Master

This block lets software on a simple word-addressed register bus reach the management registers of an Ethernet PHY over the two-wire MDC/MDIO link, using clause 22 frames. Software loads a PHY address and register number first. It starts a write by storing the 16-bit value to send. It starts a read by taking the read-command bit from 0 to 1. Software then polls an indicator register until the frame is over and collects read data from a status register.

The block generates MDC from the system clock with a programmable divider, and MDC runs only while a frame is in flight. Each frame starts with a 32-bit run of ones. Then come the start pattern 01, a 2-bit opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register number, two turnaround bits (10 when writing) and 16 data bits, all sent MSB first. MDIO changes on MDC falling edges. During a read the block releases MDIO from the first turnaround bit to the end of the frame, and it samples the PHY's data on MDC rising edges. A self-clearing reset bit in the configuration register aborts any frame and returns the controller to idle.

Register word indices on `bus_idx`: 0 configuration, 1 command, 2 address, 3 write data, 4 read status, 5 indicator. Indices 6 and 7 read as zero.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the indicator register (index 5) reads 0, the configuration register (index 0) reads 7, MDC is low and the MDIO output enable is low.
- R2: The address register (index 2) keeps the PHY address in bits 12:8 and the register number in bits 4:0, and all of its other bits read 0. Reading any register changes no state, so two reads of the indicator in a row return the same value.
- R3: A write to the write-data register (index 3) while idle sends one 64-bit frame. The frame is 32 ones, 01, opcode 01, PHY address, register number, turnaround 10 and the low 16 bits of the written value, MSB first. The output enable is high for the whole frame, and MDIO changes only when MDC falls.
- R4: Writing the command register (index 1) so that bit 0 goes from 0 to 1 while idle sends a read frame. The frame is 32 ones, 01, opcode 10, PHY address and register number. The output enable is low for the last 18 bits (turnaround and data), the data bits are sampled on MDC rising edges, and read status (index 4) bits 15:0 then return them MSB first.
- R5: Indicator bit 0 (busy) reads 1 from the cycle after a frame is launched until that frame ends. Indicator bit 2 (not-valid) is set when a read launches and clears when the read data has been stored. Not-valid is never set while busy is clear.
- R6: Writing 1 to command bit 0 when it already holds 1 starts no frame.
- R7: While busy, a write to the write-data register starts no frame and leaves that register's read-back value unchanged, and a 0-to-1 command edge starts no frame.
- R8: MDC is low whenever no frame is running. While a frame runs, the MDC period is 2 × (D + 1) system clocks, where D is configuration bits 2:0, written when bit 31 of the written value is 0.
- R9: A write to the configuration register with bit 31 set aborts any frame. It clears busy, not-valid and command bit 0, and drives MDC and the output enable low. Bit 31 reads back as 0, and the divider field keeps its value.
- R10: With the reset divider value 7, a read completes (not-valid clear) in well under 100 microseconds of system clock at 125 MHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write when high |
| bus_idx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed register (zero when not selected) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (high drives the line) |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The bench records every bit the master presents at each MDC rising edge, together with the output-enable state, and compares the frames against the clause 22 layout. A swapped opcode, turnaround or field order shows up as mismatched bits, and a line released at the wrong time shows up as a bad enable pattern. The bench also checks that a repeated 1 on the read-command bit and commands issued mid-frame start nothing. A design that fired on the level or took commands while busy would produce extra MDC edges or an overwritten data register. The bench aborts a read with the soft reset, which catches a controller that keeps clocking or leaves not-valid set. It also times the MDC period at two divider values, which catches an off-by-one in the divider.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the MDIO management master.
// Holds the register word indices and the clause 22 frame field codes,
// and a helper that assembles the 32 bits that follow the preamble.
package mdio_pkg;

    localparam int unsigned REG_IDX_W = 3;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned FIELD_W   = 5;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_CFG   = 3'd0,
        IDX_CMD   = 3'd1,
        IDX_ADDR  = 3'd2,
        IDX_WDATA = 3'd3,
        IDX_RSTAT = 3'd4,
        IDX_IND   = 3'd5
    } reg_idx_e;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE = 2'b10;

    // Builds start, opcode, addresses, turnaround and data (MSB first).
    function automatic logic [31:0] frame_body(
        input logic               rd,
        input logic [FIELD_W-1:0] phy,
        input logic [FIELD_W-1:0] regn,
        input logic [DATA_W-1:0]  data
    );
        return {SOF_CODE, (rd ? OP_READ : OP_WRITE), phy, regn,
                (rd ? 2'b11 : TA_WRITE), (rd ? {DATA_W{1'b1}} : data)};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
// Module: mdio_mdc_gen
// Produces MDC from the system clock while 'run' is high. Each half period
// lasts (div + 1) system clocks. The strobes are high in the cycle whose
// closing edge raises or drops MDC, so the frame logic can act on the same edge.
// Assumes: div stays constant during a frame; MDC idles low.
module mdio_mdc_gen #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt;
    logic             mdc_q;
    logic             hit;

    assign hit      = run && (cnt == div);
    assign rise_stb = hit && !mdc_q;
    assign fall_stb = hit && mdc_q;
    assign mdc      = mdc_q;

    // Half-period counter and MDC toggle; parked low when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || !run) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (hit) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: MDC falls back to low once the frame logic stops the clock.
    p_mdc_parks_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc_q);

    // R8: MDC only moves when the half-period count has expired (or on soft reset).
    p_mdc_moves_on_terminal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdc_q) && !$past(soft_rst)) |-> $past(hit));

endmodule

// File: rtl/mdio_frame_shifter.sv
`timescale 1ns/1ps
// Module: mdio_frame_shifter
// Runs one clause 22 frame. At launch it loads the preamble and the frame
// fields into one shift register, moves one bit out per MDC falling edge,
// releases MDIO for the turnaround and data of a read, and shifts in read data
// on MDC rising edges. The completion pulse comes on the falling edge that ends the last bit.
// Assumes: launch requests are qualified by the register block.
module mdio_frame_shifter
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               start_wr,
    input  logic               start_rd,
    input  logic [FIELD_W-1:0] phy,
    input  logic [FIELD_W-1:0] regn,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_in,
    output logic               busy,
    output logic               rd_done,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mdio_out,
    output logic               mdio_oe
);
    localparam int unsigned FRAME_LEN = PRE_LEN + 32;
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(PRE_LEN + 14);
    localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(PRE_LEN + 16);

    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     bit_idx;
    logic                 busy_q;
    logic                 is_rd;
    logic [DATA_W-1:0]    cap;
    logic                 start;
    logic                 at_last;

    assign start    = (start_wr || start_rd) && !busy_q;
    assign at_last  = (bit_idx == LAST_IDX);
    assign busy     = busy_q;
    assign rd_done  = busy_q && is_rd && fall_stb && at_last;
    assign rd_data  = cap;
    assign mdio_out = busy_q & shreg[FRAME_LEN-1];
    assign mdio_oe  = busy_q && !(is_rd && (bit_idx >= TA_IDX));

    // Frame sequencing: load at launch, advance one bit per MDC fall.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            shreg   <= '0;
            bit_idx <= '0;
            busy_q  <= 1'b0;
            is_rd   <= 1'b0;
        end else if (start) begin
            shreg   <= {{PRE_LEN{1'b1}}, frame_body(start_rd, phy, regn, wdata)};
            bit_idx <= '0;
            busy_q  <= 1'b1;
            is_rd   <= start_rd;
        end else if (busy_q && fall_stb) begin
            if (at_last) begin
                busy_q <= 1'b0;
            end else begin
                shreg   <= {shreg[FRAME_LEN-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Read data capture on MDC rising edges during the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap <= '0;
        end else if (busy_q && is_rd && rise_stb && (bit_idx >= DATA_IDX)) begin
            cap <= {cap[DATA_W-2:0], mdio_in};
        end
    end

    // R5: an accepted launch makes the frame busy on the next cycle.
    p_launch_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !soft_rst) |=> busy_q);

    // R3: inside a frame the driven bit changes only with an MDC falling edge.
    p_out_moves_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$stable(mdio_out)) |-> $past(fall_stb));

    // R4: MDIO is never driven while a read data bit is being sampled.
    p_released_at_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && is_rd && rise_stb && (bit_idx >= DATA_IDX)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_csr.sv
`timescale 1ns/1ps
// Module: mdio_csr
// Register bank and command decode. It holds the divider, the command bit, the
// address fields, the last write data, the read result and the not-valid
// flag. It turns bus writes into launch requests and the soft reset pulse.
// Assumes: busy comes from the frame shifter; reads have no side effects.
module mdio_csr
    import mdio_pkg::*;
#(
    parameter int unsigned DIV_W   = 3,
    parameter int unsigned DIV_RST = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [REG_IDX_W-1:0] bus_idx,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 busy,
    input  logic                 rd_done,
    input  logic [DATA_W-1:0]    rd_data,
    output logic                 soft_rst,
    output logic                 start_wr,
    output logic                 start_rd,
    output logic [FIELD_W-1:0]   phy,
    output logic [FIELD_W-1:0]   regn,
    output logic [DATA_W-1:0]    frame_data,
    output logic [DIV_W-1:0]     div
);
    logic               wr_hit;
    logic [DIV_W-1:0]   div_q;
    logic               cmd_q;
    logic [FIELD_W-1:0] phy_q;
    logic [FIELD_W-1:0] reg_q;
    logic [DATA_W-1:0]  wdat_q;
    logic [DATA_W-1:0]  stat_q;
    logic               nv_q;
    logic               unused_wbits;

    assign wr_hit     = bus_sel && bus_wr;
    assign soft_rst   = wr_hit && (bus_idx == IDX_CFG) && bus_wdata[31];
    assign start_wr   = wr_hit && (bus_idx == IDX_WDATA) && !busy;
    assign start_rd   = wr_hit && (bus_idx == IDX_CMD) && bus_wdata[0] && !cmd_q && !busy;
    assign phy        = phy_q;
    assign regn       = reg_q;
    assign frame_data = bus_wdata[DATA_W-1:0];
    assign div        = div_q;
    assign unused_wbits = ^bus_wdata[30:DATA_W];

    // Divider field: loaded by configuration writes without the reset bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= DIV_W'(DIV_RST);
        end else if (wr_hit && (bus_idx == IDX_CFG) && !bus_wdata[31]) begin
            div_q <= bus_wdata[DIV_W-1:0];
        end
    end

    // Command bit: remembered so only a 0-to-1 edge launches a read.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cmd_q <= 1'b0;
        end else if (wr_hit && (bus_idx == IDX_CMD)) begin
            cmd_q <= bus_wdata[0];
        end
    end

    // Address fields: PHY address and register number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q <= '0;
            reg_q <= '0;
        end else if (wr_hit && (bus_idx == IDX_ADDR)) begin
            phy_q <= bus_wdata[8 +: FIELD_W];
            reg_q <= bus_wdata[0 +: FIELD_W];
        end
    end

    // Write data: kept only when the write actually launched a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdat_q <= '0;
        end else if (start_wr) begin
            wdat_q <= bus_wdata[DATA_W-1:0];
        end
    end

    // Read result and not-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            nv_q   <= 1'b0;
        end else if (soft_rst) begin
            nv_q <= 1'b0;
        end else if (start_rd) begin
            nv_q <= 1'b1;
        end else if (rd_done) begin
            stat_q <= rd_data;
            nv_q   <= 1'b0;
        end
    end

    // Read-back multiplexer; no state changes on reads.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_idx)
                IDX_CFG:   bus_rdata = 32'(div_q);
                IDX_CMD:   bus_rdata = {31'b0, cmd_q};
                IDX_ADDR:  bus_rdata = {19'b0, phy_q, 3'b0, reg_q};
                IDX_WDATA: bus_rdata = {16'b0, wdat_q};
                IDX_RSTAT: bus_rdata = {16'b0, stat_q};
                IDX_IND:   bus_rdata = {29'b0, nv_q, 1'b0, busy};
                default:   bus_rdata = '0;
            endcase
        end
    end

    // R5: not-valid is only ever seen together with busy.
    p_notvalid_within_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        nv_q |-> busy);

    // R7: a data write while busy leaves the stored write data alone.
    p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_hit && (bus_idx == IDX_WDATA)) |=> $stable(wdat_q));

    // R9: the soft reset leaves no pending read and no command level behind.
    p_soft_reset_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!nv_q && !cmd_q));

endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
// Module: mdio_mgmt_master (top)
// Register-programmed clause 22 MDIO management master. It ties the register
// bank, the MDC generator and the frame shifter together.
// Assumes: one system clock, synchronous active-low reset, and external
// tristate pad logic driven by mdio_out and mdio_oe.
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32,
    parameter int unsigned DIV_W   = 3,
    parameter int unsigned DIV_RST = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [REG_IDX_W-1:0] bus_idx,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 mdc,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    input  logic                 mdio_in
);
    logic               soft_rst;
    logic               start_wr;
    logic               start_rd;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
    logic [DATA_W-1:0]  frame_data;
    logic [DIV_W-1:0]   div;
    logic               busy;
    logic               rd_done;
    logic [DATA_W-1:0]  rd_data;
    logic               rise_stb;
    logic               fall_stb;

    mdio_csr #(
        .DIV_W   (DIV_W),
        .DIV_RST (DIV_RST)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_idx    (bus_idx),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .rd_done    (rd_done),
        .rd_data    (rd_data),
        .soft_rst   (soft_rst),
        .start_wr   (start_wr),
        .start_rd   (start_rd),
        .phy        (phy),
        .regn       (regn),
        .frame_data (frame_data),
        .div        (div)
    );

    mdio_mdc_gen #(
        .DIV_W (DIV_W)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .run      (busy),
        .div      (div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_shifter #(
        .PRE_LEN (PRE_LEN)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .phy      (phy),
        .regn     (regn),
        .wdata    (frame_data),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_in  (mdio_in),
        .busy     (busy),
        .rd_done  (rd_done),
        .rd_data  (rd_data),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: tb/mdio_mgmt_master_test.sv
`timescale 1ns/1ps
// Directed bench for mdio_mgmt_master: a PHY model records the frame bits at
// MDC rising edges and returns a data pattern during reads.
module mdio_mgmt_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_idx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;

    int          rise_cnt = 0;
    logic        cap_out [0:127];
    logic        cap_oe  [0:127];
    longint      t_rise  [0:1];
    logic [15:0] phy_pat = 16'h0000;

    always #4 clk = ~clk;

    mdio_mgmt_master uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // PHY model: record the line at each MDC rising edge.
    always @(posedge mdc) begin
        if (rise_cnt < 128) begin
            cap_out[rise_cnt] = mdio_out;
            cap_oe[rise_cnt]  = mdio_oe;
        end
        if (rise_cnt < 2) t_rise[rise_cnt] = $time;
        rise_cnt = rise_cnt + 1;
    end

    // PHY model: present read data after each MDC falling edge.
    always @(negedge mdc) begin
        mdio_in <= (rise_cnt >= 48 && rise_cnt < 64) ? phy_pat[63 - rise_cnt] : 1'b1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] idx, output logic [31:0] data);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_idx = idx;
        #1 data = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        bus_read(3'd5, v);
        while (v[0] && n < 5000) begin
            bus_read(3'd5, v);
            n++;
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        bus_read(3'd5, v); check("R1 indicator after reset", v, 32'h0);
        bus_read(3'd0, v); check("R1 config after reset", v, 32'h7);
        check("R1 mdc low", {31'b0, mdc}, 32'h0);
        check("R1 oe low", {31'b0, mdio_oe}, 32'h0);
    endtask

    task automatic t_addr_reg();
        logic [31:0] v, w;
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read(3'd2, v); check("R2 address fields", v, 32'h0000_1F1F);
        bus_read(3'd5, v); bus_read(3'd5, w);
        check("R2 repeated read no side effect", w, v);
    endtask

    task automatic t_write_frame();
        logic [31:0] v;
        logic [63:0] e;
        int bad_out = 0, bad_oe = 0;
        bus_write(3'd0, 32'h1);
        bus_read(3'd0, v); check("R8 divider field written", v, 32'h1);
        bus_write(3'd2, 32'h0000_150A);
        rise_cnt = 0;
        bus_write(3'd3, 32'h0000_A53C);
        bus_read(3'd5, v); check("R5 busy during write", v, 32'h1);
        wait_idle();
        check("R3 write frame length", rise_cnt, 64);
        e = exp_frame(1'b0, 5'h15, 5'h0A, 16'hA53C);
        for (int k = 0; k < 64; k++) begin
            if (cap_out[k] !== e[63-k]) bad_out++;
            if (cap_oe[k] !== 1'b1) bad_oe++;
        end
        check("R3 write frame bits", bad_out, 0);
        check("R3 write frame driven", bad_oe, 0);
        check("R8 mdc period div1 (ns)", 32'(t_rise[1] - t_rise[0]), 32'd32);
        check("R8 mdc low after frame", {31'b0, mdc}, 32'h0);
        bus_read(3'd3, v); check("R3 write data readback", v, 32'h0000_A53C);
    endtask

    task automatic t_read_frame();
        logic [31:0] v;
        logic [63:0] e;
        int bad_out = 0, bad_oe = 0;
        phy_pat = 16'h5AC3;
        bus_write(3'd2, 32'h0000_0913);
        bus_write(3'd1, 32'h0);
        rise_cnt = 0;
        bus_write(3'd1, 32'h1);
        bus_read(3'd5, v); check("R5 busy and not-valid during read", v, 32'h5);
        wait_idle();
        check("R4 read frame length", rise_cnt, 64);
        e = exp_frame(1'b1, 5'h09, 5'h13, 16'h0);
        for (int k = 0; k < 64; k++) begin
            if (k < 46 && cap_out[k] !== e[63-k]) bad_out++;
            if (cap_oe[k] !== ((k < 46) ? 1'b1 : 1'b0)) bad_oe++;
        end
        check("R4 read header bits", bad_out, 0);
        check("R4 read release pattern", bad_oe, 0);
        bus_read(3'd4, v); check("R4 read status data", v, 32'h0000_5AC3);
        bus_read(3'd5, v); check("R5 indicator after read", v, 32'h0);
    endtask

    task automatic t_level_no_restart();
        logic [31:0] v;
        rise_cnt = 0;
        bus_write(3'd1, 32'h1);
        repeat (20) @(negedge clk);
        check("R6 repeated one starts nothing", rise_cnt, 0);
        bus_read(3'd5, v); check("R6 indicator stays idle", v, 32'h0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        int bad = 0;
        bus_write(3'd1, 32'h0);
        rise_cnt = 0;
        bus_write(3'd3, 32'h0000_1111);
        bus_write(3'd3, 32'h0000_2222);
        bus_write(3'd1, 32'h1);
        wait_idle();
        repeat (40) @(negedge clk);
        check("R7 only one frame while busy", rise_cnt, 64);
        bus_read(3'd3, v); check("R7 write data unchanged", v, 32'h0000_1111);
        for (int k = 0; k < 16; k++) if (cap_out[48+k] !== 1'(16'h1111 >> (15-k))) bad++;
        check("R7 frame carried first data", bad, 0);
        bus_read(3'd5, v); check("R7 idle afterwards", v, 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        int saved;
        bus_write(3'd1, 32'h0);
        rise_cnt = 0;
        bus_write(3'd1, 32'h1);
        repeat (30) @(negedge clk);
        bus_read(3'd5, v); check("R9 read in flight", v, 32'h5);
        bus_write(3'd0, 32'h8000_0000);
        check("R9 mdc low after soft reset", {31'b0, mdc}, 32'h0);
        check("R9 oe low after soft reset", {31'b0, mdio_oe}, 32'h0);
        bus_read(3'd5, v); check("R9 indicator cleared", v, 32'h0);
        bus_read(3'd1, v); check("R9 command cleared", v, 32'h0);
        bus_read(3'd0, v); check("R9 divider kept, bit31 reads 0", v, 32'h1);
        saved = rise_cnt;
        repeat (50) @(negedge clk);
        check("R9 no further MDC edges", rise_cnt, saved);
    endtask

    task automatic t_default_speed();
        logic [31:0] v;
        longint t0;
        int n = 0;
        bus_write(3'd0, 32'h7);
        bus_read(3'd0, v); check("R10 default divider", v, 32'h7);
        phy_pat = 16'hC0DE;
        bus_write(3'd1, 32'h0);
        rise_cnt = 0;
        t0 = $time;
        bus_write(3'd1, 32'h1);
        bus_read(3'd5, v);
        while (v[2] && n < 5000) begin
            bus_read(3'd5, v);
            n++;
        end
        check("R10 read done under 100us", {31'b0, ($time - t0) < 100000}, 32'h1);
        check("R8 mdc period div7 (ns)", 32'(t_rise[1] - t_rise[0]), 32'd128);
        bus_read(3'd4, v); check("R10 read status data", v, 32'h0000_C0DE);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_addr_reg();
        t_write_frame();
        t_read_frame();
        t_level_no_restart();
        t_busy_ignore();
        t_soft_reset();
        t_default_speed();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule